// File: doc/BRIEF.md
# Paged Register Access SPI Slave

This block lets an external host read and write byte-wide internal registers over a four-wire SPI link. The link uses serial clock, active-low select, host-to-slave data and slave-to-host data. The block runs on its own internal clock and oversamples the SPI lines through synchronisers. Each select-active transaction starts with one address byte. Bit 7 of that byte picks the direction, and bits 6..0 pick an offset inside a 128-byte page. An external page value supplies the upper address bits. Data bytes follow the address byte, and their number is not fixed. When the incremental input is high, the offset steps by one after each data byte, so a burst reaches consecutive registers.

A ready output tells the host when the next byte may start. It stays low for a minimum time around select edges. It also stays low after every byte while the block issues the register-file request for that byte, or waits for read data. If the host clocks data while ready is low, an error flag is raised and held, and ready is forced low. Both stay that way until select is released. On the register-file side the block issues single-cycle byte read and write strobes with a full address. Read data is expected on the cycle after a read strobe.

Top module: `spi_paged_slave`

## Requirements
- R1: Bit 7 of the first byte after select assertion sets the direction: 1 = read, 0 = write. A write address byte issues no register-file access. A read address byte issues one read strobe.
- R2: Every request address is the page input in the upper PAGE_W bits, joined with a 7-bit offset in bits 6..0. The first data byte uses the offset from address bits 6..0.
- R3: With the incremental input high, each data byte after the first uses the previous offset plus one. The offset wraps from 0x7F to 0x00 inside the same page.
- R4: With the incremental input low, every data byte of a transaction uses the same address.
- R5: Data moves most significant bit first. The host data line is sampled on rising serial-clock edges. The slave data line changes on falling edges, and bit 7 of a read byte is on it before the byte's first rising edge.
- R6: After a completed byte, ready goes low. It stays low for WR_GAP internal clocks after a write address byte or a write data byte, and for RD_GAP internal clocks after a read address byte or a read data byte.
- R7: Ready is low for HOLD_CLKS internal clocks after select is released, and for at least SETUP_CLKS internal clocks after select is asserted.
- R8: If select is released partway through a byte, that byte is dropped and no access is issued. The next transaction starts byte alignment afresh.
- R9: A rising serial-clock edge while ready is low sets the error output. The flag then holds ready low, and bytes are ignored until select is released, which clears the flag.
- R10: After reset, ready is high, error is low, both strobes are low and the slave data line is 0.
- R11: Read and write strobes are never active together. Each read data byte that completes triggers exactly one read strobe for the next byte. The value on the read-data input in the cycle after a read strobe is what gets shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | SPI select, active low |
| spi_mosi | input | 1 | Host-to-slave serial data |
| spi_miso | output | 1 | Slave-to-host serial data |
| rdy | output | 1 | High when the host may start the next byte |
| err | output | 1 | Protocol error flag, held until select release |
| inc_mode | input | 1 | 1 = offset steps after each data byte |
| page | input | PAGE_W | Upper address bits |
| wr_req | output | 1 | Single-cycle write strobe |
| rd_req | output | 1 | Single-cycle read strobe |
| req_addr | output | PAGE_W+7 | Request address |
| wr_data | output | 8 | Write data |
| rd_data | input | 8 | Read data, valid the cycle after rd_req |

## Verification
The bench uses the default parameters: a 4-bit page, two synchroniser stages, and guard times of 2, 5, 14 and 4 clocks. With a 4-bit page the whole 2048-byte address space fits in a bench memory, so every request address can be checked against stored data. It also means the top offset of the highest page, and its wrap, are exercised directly. The write and read gaps differ by nine clocks. Ready sampled ten clocks after a byte's last rising edge therefore tells the two gap lengths apart. The short read gap also lets a directed case clock a byte into the busy window to raise the error flag.

// File: rtl/spi_pr_pkg.sv
package spi_pr_pkg;
  localparam int OFF_W  = 7;
  localparam int BYTE_W = 8;

  typedef enum logic {
    PH_ADDR = 1'b0,
    PH_DATA = 1'b1
  } phase_e;
endpackage

// File: rtl/spi_pr_sync.sv
module spi_pr_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = d;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/spi_pr_shift.sv
module spi_pr_shift
  import spi_pr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ss_act,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              mosi_s,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_data,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_val,
  output logic              miso
);
  logic [2:0]        bit_cnt_q, bit_cnt_d;
  logic [BYTE_W-2:0] rx_q, rx_d;
  logic [BYTE_W-1:0] tx_q, tx_d;
  logic              shift_en;

  assign shift_en  = ss_act && sclk_rise;
  assign byte_done = shift_en && (bit_cnt_q == 3'd7);
  assign byte_val  = {rx_q, mosi_s};

  always_comb begin
    bit_cnt_d = bit_cnt_q;
    rx_d      = rx_q;
    if (!ss_act) begin
      bit_cnt_d = 3'd0;
    end else if (shift_en) begin
      bit_cnt_d = bit_cnt_q + 3'd1;
      rx_d      = {rx_q[BYTE_W-3:0], mosi_s};
    end
  end

  always_comb begin
    tx_d = tx_q;
    if (load)
      tx_d = load_data;
    else if (ss_act && sclk_fall && (bit_cnt_q != 3'd0))
      tx_d = {tx_q[BYTE_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt_q <= 3'd0;
      rx_q      <= '0;
      tx_q      <= '0;
    end else begin
      bit_cnt_q <= bit_cnt_d;
      rx_q      <= rx_d;
      tx_q      <= tx_d;
    end
  end

  assign miso = tx_q[BYTE_W-1];

  assert_idle_realign_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_act |=> (bit_cnt_q == 3'd0));
endmodule

// File: rtl/spi_pr_ctrl.sv
module spi_pr_ctrl
  import spi_pr_pkg::*;
#(
  parameter int PAGE_W     = 4,
  parameter int SETUP_CLKS = 2,
  parameter int WR_GAP     = 5,
  parameter int RD_GAP     = 14,
  parameter int HOLD_CLKS  = 4,
  localparam int ADDR_W    = PAGE_W + OFF_W,
  localparam int MAX_A     = (WR_GAP > RD_GAP) ? WR_GAP : RD_GAP,
  localparam int MAX_B     = (SETUP_CLKS > HOLD_CLKS) ? SETUP_CLKS : HOLD_CLKS,
  localparam int MAX_WAIT  = (MAX_A > MAX_B) ? MAX_A : MAX_B,
  localparam int CNT_W     = $clog2(MAX_WAIT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ss_act,
  input  logic              ss_assert,
  input  logic              ss_release,
  input  logic              sclk_rise,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] byte_val,
  input  logic              inc_mode,
  input  logic [PAGE_W-1:0] page,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              rdy,
  output logic              err,
  output logic              wr_req,
  output logic              rd_req,
  output logic [ADDR_W-1:0] req_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              tx_load,
  output logic [BYTE_W-1:0] tx_data
);
  logic [CNT_W-1:0]  wait_q, wait_d;
  logic              err_q, err_d;
  phase_e            phase_q, phase_d;
  logic              dir_q, dir_d;
  logic [OFF_W-1:0]  off_q, off_d, off_nxt;
  logic              wr_q, wr_d, rd_q, rd_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [BYTE_W-1:0] wdat_q, wdat_d;
  logic              load_q;
  logic              busy;

  assign busy    = (wait_q != '0) || err_q;
  assign off_nxt = inc_mode ? (off_q + OFF_W'(1)) : off_q;

  always_comb begin
    wait_d  = (wait_q != '0) ? (wait_q - CNT_W'(1)) : wait_q;
    err_d   = err_q;
    phase_d = phase_q;
    dir_d   = dir_q;
    off_d   = off_q;
    wr_d    = 1'b0;
    rd_d    = 1'b0;
    addr_d  = addr_q;
    wdat_d  = wdat_q;
    if (ss_release) begin
      err_d   = 1'b0;
      phase_d = PH_ADDR;
      wait_d  = CNT_W'(HOLD_CLKS);
    end else if (ss_assert) begin
      phase_d = PH_ADDR;
      if (wait_q <= CNT_W'(SETUP_CLKS))
        wait_d = CNT_W'(SETUP_CLKS);
    end else if (ss_act && sclk_rise && busy) begin
      err_d = 1'b1;
    end else if (byte_done) begin
      if (phase_q == PH_ADDR) begin
        phase_d = PH_DATA;
        dir_d   = byte_val[BYTE_W-1];
        off_d   = byte_val[OFF_W-1:0];
        if (byte_val[BYTE_W-1]) begin
          rd_d   = 1'b1;
          addr_d = {page, byte_val[OFF_W-1:0]};
          wait_d = CNT_W'(RD_GAP);
        end else begin
          wait_d = CNT_W'(WR_GAP);
        end
      end else if (!dir_q) begin
        wr_d   = 1'b1;
        addr_d = {page, off_q};
        wdat_d = byte_val;
        off_d  = off_nxt;
        wait_d = CNT_W'(WR_GAP);
      end else begin
        rd_d   = 1'b1;
        addr_d = {page, off_nxt};
        off_d  = off_nxt;
        wait_d = CNT_W'(RD_GAP);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q  <= '0;
      err_q   <= 1'b0;
      phase_q <= PH_ADDR;
      dir_q   <= 1'b0;
      off_q   <= '0;
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
      addr_q  <= '0;
      wdat_q  <= '0;
      load_q  <= 1'b0;
    end else begin
      wait_q  <= wait_d;
      err_q   <= err_d;
      phase_q <= phase_d;
      dir_q   <= dir_d;
      off_q   <= off_d;
      wr_q    <= wr_d;
      rd_q    <= rd_d;
      addr_q  <= addr_d;
      wdat_q  <= wdat_d;
      load_q  <= rd_q;
    end
  end

  assign rdy      = !busy;
  assign err      = err_q;
  assign wr_req   = wr_q;
  assign rd_req   = rd_q;
  assign req_addr = addr_q;
  assign wr_data  = wdat_q;
  assign tx_load  = load_q;
  assign tx_data  = rd_data;

  assert_single_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_q && rd_q));
  assert_strobe_not_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_q || rd_q) |-> !rdy);
  assert_no_access_in_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_q || rd_q) |-> !err_q);
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !ss_release) |=> err_q);
  assert_release_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ss_release |=> (!err_q && !rdy));
endmodule

// File: rtl/spi_paged_slave.sv
module spi_paged_slave
  import spi_pr_pkg::*;
#(
  parameter int PAGE_W      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int SETUP_CLKS  = 2,
  parameter int WR_GAP      = 5,
  parameter int RD_GAP      = 14,
  parameter int HOLD_CLKS   = 4,
  localparam int ADDR_W     = PAGE_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              rdy,
  output logic              err,
  input  logic              inc_mode,
  input  logic [PAGE_W-1:0] page,
  output logic              wr_req,
  output logic              rd_req,
  output logic [ADDR_W-1:0] req_addr,
  output logic [BYTE_W-1:0] wr_data,
  input  logic [BYTE_W-1:0] rd_data
);
  logic sclk_s, cs_n_s, mosi_s;
  logic sclk_prev_q, cs_prev_q;
  logic sclk_rise, sclk_fall, ss_act, ss_assert, ss_release;
  logic byte_done, tx_load;
  logic [BYTE_W-1:0] byte_val, tx_data;

  spi_pr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
    .clk(clk), .rst_n(rst_n), .d(spi_sclk), .q(sclk_s));
  spi_pr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
    .clk(clk), .rst_n(rst_n), .d(spi_cs_n), .q(cs_n_s));
  spi_pr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mosi (
    .clk(clk), .rst_n(rst_n), .d(spi_mosi), .q(mosi_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev_q <= 1'b0;
      cs_prev_q   <= 1'b1;
    end else begin
      sclk_prev_q <= sclk_s;
      cs_prev_q   <= cs_n_s;
    end
  end

  assign sclk_rise  = sclk_s && !sclk_prev_q;
  assign sclk_fall  = !sclk_s && sclk_prev_q;
  assign ss_act     = !cs_n_s;
  assign ss_assert  = cs_prev_q && !cs_n_s;
  assign ss_release = !cs_prev_q && cs_n_s;

  spi_pr_shift u_shift (
    .clk(clk), .rst_n(rst_n), .ss_act(ss_act),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .mosi_s(mosi_s),
    .load(tx_load), .load_data(tx_data),
    .byte_done(byte_done), .byte_val(byte_val), .miso(spi_miso));

  spi_pr_ctrl #(
    .PAGE_W(PAGE_W), .SETUP_CLKS(SETUP_CLKS), .WR_GAP(WR_GAP),
    .RD_GAP(RD_GAP), .HOLD_CLKS(HOLD_CLKS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ss_act(ss_act), .ss_assert(ss_assert),
    .ss_release(ss_release), .sclk_rise(sclk_rise), .byte_done(byte_done),
    .byte_val(byte_val), .inc_mode(inc_mode), .page(page), .rd_data(rd_data),
    .rdy(rdy), .err(err), .wr_req(wr_req), .rd_req(rd_req),
    .req_addr(req_addr), .wr_data(wr_data), .tx_load(tx_load),
    .tx_data(tx_data));
endmodule

// File: tb/spi_paged_slave_tb.sv
module spi_paged_slave_tb;
  localparam int PAGE_W = 4;
  localparam int ADDR_W = PAGE_W + 7;

  logic clk, rst_n, sclk, cs_n, mosi, miso, rdy, err, inc_mode;
  logic [PAGE_W-1:0] page;
  logic wr_req, rd_req;
  logic [ADDR_W-1:0] req_addr;
  logic [7:0] wr_data, rd_data;

  spi_paged_slave #(.PAGE_W(PAGE_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_miso(miso), .rdy(rdy), .err(err),
    .inc_mode(inc_mode), .page(page), .wr_req(wr_req), .rd_req(rd_req),
    .req_addr(req_addr), .wr_data(wr_data), .rd_data(rd_data));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // register-file model and request log
  logic [7:0] mem [0:(1<<ADDR_W)-1];
  logic [ADDR_W-1:0] wr_log_a [0:15];
  logic [7:0]        wr_log_d [0:15];
  logic [ADDR_W-1:0] rd_log_a [0:15];
  int wr_cnt = 0, rd_cnt = 0, both_cnt = 0;
  always @(posedge clk) begin
    if (wr_req) begin
      mem[req_addr] <= wr_data;
      wr_log_a[wr_cnt[3:0]] <= req_addr;
      wr_log_d[wr_cnt[3:0]] <= wr_data;
      wr_cnt <= wr_cnt + 1;
    end
    if (rd_req) begin
      rd_data <= mem[req_addr];
      rd_log_a[rd_cnt[3:0]] <= req_addr;
      rd_cnt <= rd_cnt + 1;
    end
    if (wr_req && rd_req) both_cnt <= both_cnt + 1;
  end

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic rdy_mid;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_rdy();
    for (int i = 0; i < 200 && !rdy; i++) @(negedge clk);
  endtask

  task automatic ss_on();
    cs_n = 1'b0; clks(6); wait_rdy();
  endtask

  task automatic ss_off();
    cs_n = 1'b1; clks(12);
  endtask

  // one byte, MSB first; rdy sampled 10 clocks after the last rising edge
  task automatic xfer(input logic [7:0] tx, input int tail, output logic [7:0] rx);
    for (int b = 7; b >= 0; b--) begin
      mosi = tx[b];
      clks(8);
      rx[b] = miso;
      sclk = 1'b1;
      clks(b == 0 ? 10 : 8);
      if (b == 0) rdy_mid = rdy;
      sclk = 1'b0;
    end
    clks(tail);
  endtask

  // vector: inc(1) page(4) off(7) d0(8) d1(8)
  localparam logic [27:0] VEC [4] = '{
    {1'b1, 4'd3,  7'h0A, 8'hA5, 8'h3C},
    {1'b0, 4'd7,  7'h14, 8'h11, 8'hE2},
    {1'b1, 4'd15, 7'h7F, 8'h81, 8'h7E},
    {1'b1, 4'd0,  7'h00, 8'hFF, 8'h00}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] rx, r0, r1;
    int w0, rc0;
    rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; mosi = 1'b0;
    inc_mode = 1'b0; page = '0;
    clks(4);
    // R10: reset state
    check("R10 rdy", rdy, 1);
    check("R10 err", err, 0);
    check("R10 strobes", {wr_req, rd_req}, 0);
    check("R10 miso", miso, 0);
    rst_n = 1'b1;
    clks(4);

    foreach (VEC[i]) begin
      logic inc; logic [3:0] pg; logic [6:0] off; logic [7:0] d0, d1;
      logic [ADDR_W-1:0] a0, a1;
      {inc, pg, off, d0, d1} = VEC[i];
      a0 = {pg, off};
      a1 = {pg, inc ? off + 7'd1 : off};
      inc_mode = inc; page = pg;
      w0 = wr_cnt; rc0 = rd_cnt;
      ss_on();
      xfer({1'b0, off}, 8, rx);
      check("R6 write gap over", rdy_mid, 1);
      check("R1 write addr no access", (wr_cnt - w0) + (rd_cnt - rc0), 0);
      wait_rdy(); xfer(d0, 8, rx);
      wait_rdy(); xfer(d1, 8, rx);
      ss_off();
      check("R1 two writes", wr_cnt - w0, 2);
      check("R2 first write addr", wr_log_a[w0[3:0]], a0);
      check("R5 first write data", wr_log_d[w0[3:0]], d0);
      check(inc ? "R3 second write addr" : "R4 second write addr", wr_log_a[(w0 + 1) % 16], a1);
      check("R5 second write data", wr_log_d[(w0 + 1) % 16], d1);
      rc0 = rd_cnt;
      ss_on();
      xfer({1'b1, off}, 8, rx);
      check("R6 read gap still busy", rdy_mid, 0);
      wait_rdy(); xfer(8'h00, 8, r0);
      wait_rdy(); xfer(8'h00, 8, r1);
      ss_off();
      check("R11 read strobes", rd_cnt - rc0, 3);
      check("R2 read addr", rd_log_a[rc0 % 16], a0);
      check("R5 first read byte", r0, inc ? d0 : d1);
      check(inc ? "R3 second read byte" : "R4 second read byte", r1, d1);
    end

    // R7: guard windows around select edges
    cs_n = 1'b0; clks(12);
    cs_n = 1'b1; clks(5);
    check("R7 hold after release", rdy, 0);
    clks(10);
    check("R7 ready after hold", rdy, 1);
    cs_n = 1'b0; clks(3);
    check("R7 setup after assert", rdy, 0);
    clks(5);
    check("R7 ready after setup", rdy, 1);
    ss_off();

    // R8: partial byte dropped, realigned next transaction
    inc_mode = 1'b0; page = 4'd5;
    w0 = wr_cnt;
    ss_on();
    for (int b = 0; b < 4; b++) begin
      mosi = 1'b1; clks(8); sclk = 1'b1; clks(8); sclk = 1'b0;
    end
    ss_off();
    check("R8 no access on partial", (wr_cnt - w0) + both_cnt, 0);
    ss_on();
    xfer(8'h33, 8, rx); wait_rdy(); xfer(8'h5A, 8, rx);
    ss_off();
    check("R8 realigned addr", wr_log_a[w0[3:0]], {4'd5, 7'h33});
    check("R8 realigned data", wr_log_d[w0[3:0]], 8'h5A);

    // R9: clocking into the busy window raises the error
    rc0 = rd_cnt; w0 = wr_cnt;
    ss_on();
    xfer({1'b1, 7'h10}, 0, rx);
    clks(2); sclk = 1'b1; clks(8); sclk = 1'b0;
    clks(4);
    check("R9 err set", err, 1);
    check("R9 rdy low", rdy, 0);
    for (int b = 0; b < 7; b++) begin
      clks(8); sclk = 1'b1; clks(8); sclk = 1'b0;
    end
    clks(30);
    check("R9 still err", err, 1);
    check("R9 byte ignored", (rd_cnt - rc0) + (wr_cnt - w0), 1);
    ss_off();
    check("R9 cleared by release", err, 0);
    check("R11 no double strobe", both_cnt, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule